// File: doc/BRIEF.md
# Interrupting Periodic Timer

This block is a timer peripheral that sits on a simple register bus. The bus has one write port and one read port, and each port carries its own address. The timer holds three registers: a control word, a free-running cycle count and a period limit. While counting is enabled, the count advances once per clock. When the count reaches the period, it folds back to zero and latches a pending event. With interrupts enabled, that pending event drives a level interrupt line to the processor. The line stays high until software acknowledges it.

The block answers to addresses at or above a base address, by default 0x1000_0000. Writes below the base never reach it. For reads below the base, and for reads of unused offsets in its window, it returns zero, so the system can mux in other memory. The usual software sequence has three steps. First, program the period. Then write 0x7 to the control word, which starts counting, enables the interrupt and acknowledges any old event. In the handler, write 0x7 again to acknowledge and keep running. Writing 0x0 stops everything.

Top module: `periodic_timer`

## Requirements
- R1: After reset, all three registers read zero and `irq` is low.
- R2: A write whose address is below the base changes no register.
- R3: The control word sits at offset 0x0. Bit 0 enables counting and bit 1 enables the interrupt, and both are plain read/write. Bit 2 is the pending flag, and reading the word returns it there. Bits 31..3 always read zero.
- R4: With counting enabled, the count rises by one on every clock. With counting disabled, it holds its value.
- R5: On an edge where counting is enabled and count >= period, the count becomes zero and pending is set. A period of P therefore gives one event every P+1 clocks.
- R6: `irq` is high exactly while pending and interrupt enable are both set. It remains high without further events until pending is cleared or the enable is dropped.
- R7: Writing the control word with bit 2 = 1 clears pending. Writing it with bit 2 = 0 leaves pending unchanged.
- R8: If a clearing write and a wrap land on the same edge, pending stays set.
- R9: Reads return the count at offset 0x4 and the period at offset 0x8. Reads at any other offset, or below the base, return zero.
- R10: The count register is read-only, and a write to offset 0x4 leaves it unchanged.
- R11: Writing 0x0 to the control word stops counting and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 32 | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that a write strobe lasts one clock and that `wr_addr` and `wr_data` are stable around that edge. They also assume that nothing outside the block changes the count. The stimulus changes bus inputs only on the falling clock edge and raises each strobe for exactly one rising edge. It returns to reset before each scenario, so cycle positions relative to the enabling write are known. The same-edge collision is placed by counting clocks from that write.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned OFF_CTRL   = 0;
  localparam int unsigned OFF_COUNT  = 4;
  localparam int unsigned OFF_PERIOD = 8;

  localparam int unsigned BIT_CE   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_PEND = 2;

  typedef struct packed {
    logic pend;
    logic irq_en;
    logic cnt_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ptmr_addr_dec.sv
module ptmr_addr_dec
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              req,
  output logic              sel_ctrl,
  output logic              sel_count,
  output logic              sel_period
);
  logic              in_win;
  logic [ADDR_W-1:0] off;

  assign in_win     = (addr >= BASE);
  assign off        = addr - BASE;
  assign sel_ctrl   = req & in_win & (off == ADDR_W'(OFF_CTRL));
  assign sel_count  = req & in_win & (off == ADDR_W'(OFF_COUNT));
  assign sel_period = req & in_win & (off == ADDR_W'(OFF_PERIOD));
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] count_q;

  // >= so that shrinking the period below the live count still folds at once
  assign wrap  = run && (count_q >= period);
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (run) begin
      count_q <= wrap ? '0 : count_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_period,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] period,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] period_q;
  logic              ack;

  assign ack = wr_ctrl & wdata[BIT_PEND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.cnt_en <= wdata[BIT_CE];
        ctrl_q.irq_en <= wdata[BIT_IE];
      end
      // a fresh event outranks an acknowledge on the same edge
      ctrl_q.pend <= wrap | (ctrl_q.pend & ~ack);
      if (wr_period) begin
        period_q <= wdata;
      end
    end
  end

  assign ctrl   = ctrl_q;
  assign period = period_q;
  assign irq    = ctrl_q.pend & ctrl_q.irq_en;
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic              w_ctrl, w_count, w_period;
  logic              r_ctrl, r_count, r_period;
  ctrl_t             ctrl_q;
  logic [CTRL_W-1:0] ctrl_bits;
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] count_q;
  logic              wrap;
  logic              w_count_unused;

  ptmr_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_wdec (
    .addr(wr_addr), .req(wr_en),
    .sel_ctrl(w_ctrl), .sel_count(w_count), .sel_period(w_period)
  );

  ptmr_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_rdec (
    .addr(rd_addr), .req(1'b1),
    .sel_ctrl(r_ctrl), .sel_count(r_count), .sel_period(r_period)
  );

  // count is read-only: its write select is decoded but deliberately dropped
  assign w_count_unused = w_count;

  ptmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(w_ctrl), .wr_period(w_period), .wdata(wr_data),
    .wrap(wrap), .ctrl(ctrl_q), .period(period_q), .irq(irq)
  );

  ptmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.cnt_en),
    .period(period_q), .count(count_q), .wrap(wrap)
  );

  assign ctrl_bits = ctrl_q;

  always_comb begin
    rd_data = '0;
    if (r_ctrl)   rd_data = DATA_W'(ctrl_bits);
    if (r_count)  rd_data = count_q;
    if (r_period) rd_data = period_q;
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_ack_bit,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] period,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic              irq
);
  logic ce, ie, pend, ack_wr;
  assign ce     = ctrl_bits[BIT_CE];
  assign ie     = ctrl_bits[BIT_IE];
  assign pend   = ctrl_bits[BIT_PEND];
  assign ack_wr = wr_en && (wr_addr == BASE) && wr_ack_bit;

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt < period) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> (cnt == $past(cnt)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt >= period) |=> (cnt == '0 && pend));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack_wr) |=> pend);

  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ce && cnt >= period) |=> pend);

  p_low_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < BASE) |=> ($stable(period) && $stable(ce) && $stable(ie)));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(pend) || $rose(ie)));
endmodule

bind periodic_timer ptmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_ack_bit(wr_data[2]), .cnt(count_q), .period(period_q),
  .ctrl_bits(ctrl_bits), .irq(irq)
);

// File: tb/test_periodic_timer.sv
module test_periodic_timer;
  localparam int CLK_PERIOD = 20;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] A_CTRL = BASE;
  localparam logic [31:0] A_CNT  = BASE + 32'h4;
  localparam logic [31:0] A_PER  = BASE + 32'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_timer i_periodic_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [31:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read @%0h", a), rd_data, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1;
    chk(req, "irq", {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk_reg("R1", A_CTRL, 32'h0);
    chk_reg("R1", A_CNT, 32'h0);
    chk_reg("R1", A_PER, 32'h0);
    chk_irq("R1", 1'b0);
  endtask

  task automatic t_decode();
    do_reset();
    wr(32'h0FFF_FFF8, 32'd123);
    wr(32'h0000_0000, 32'h7);
    chk_reg("R2", A_PER, 32'h0);
    chk_reg("R2", A_CTRL, 32'h0);
    wr(A_PER, 32'd55);
    chk_reg("R9", A_PER, 32'd55);
    chk_reg("R9", BASE + 32'hC, 32'h0);
    chk_reg("R9", 32'h0000_0008, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFF2);
    chk_reg("R3", A_CTRL, 32'h2);
    wait_clk(3);
    chk_reg("R4", A_CNT, 32'h0);
    wr(A_CNT, 32'd77);
    chk_reg("R10", A_CNT, 32'h0);
  endtask

  task automatic t_periodic();
    do_reset();
    wr(A_PER, 32'd4);
    wr(A_CTRL, 32'h3);
    chk_reg("R3", A_CTRL, 32'h3);
    chk_reg("R4", A_CNT, 32'h0);
    wait_clk(4);
    chk_reg("R4", A_CNT, 32'd4);
    chk_irq("R5", 1'b0);
    wait_clk(1);
    chk_reg("R5", A_CNT, 32'd0);
    chk_reg("R5", A_CTRL, 32'h7);
    chk_irq("R6", 1'b1);
    wait_clk(5);
    chk_irq("R6", 1'b1);
    wr(A_CTRL, 32'h7);
    chk_reg("R7", A_CTRL, 32'h3);
    chk_irq("R7", 1'b0);
    wait_clk(3);
    chk_irq("R5", 1'b0);
    wait_clk(1);
    chk_irq("R5", 1'b1);
    wr(A_CTRL, 32'h1);
    chk_reg("R6", A_CTRL, 32'h5);
    chk_irq("R6", 1'b0);
    wr(A_CTRL, 32'h3);
    chk_reg("R7", A_CTRL, 32'h7);
    chk_irq("R6", 1'b1);
  endtask

  task automatic t_stop();
    logic [31:0] held;
    wr(A_CTRL, 32'h0);
    chk_irq("R11", 1'b0);
    chk_reg("R11", A_CTRL, 32'h4);
    rd_addr = A_CNT;
    #1;
    held = rd_data;
    wait_clk(3);
    chk_reg("R11", A_CNT, held);
  endtask

  task automatic t_collide();
    do_reset();
    wr(A_PER, 32'd4);
    wr(A_CTRL, 32'h3);
    wait_clk(9);
    chk_reg("R8", A_CNT, 32'd4);
    wr(A_CTRL, 32'h7);
    chk_reg("R8", A_CNT, 32'd0);
    chk_reg("R8", A_CTRL, 32'h7);
    chk_irq("R8", 1'b1);
    wr(A_CTRL, 32'h7);
    chk_reg("R7", A_CTRL, 32'h3);
  endtask

  task automatic t_shrink();
    do_reset();
    wr(A_PER, 32'd100);
    wr(A_CTRL, 32'h3);
    wait_clk(9);
    wr(A_PER, 32'd3);
    chk_reg("R4", A_CNT, 32'd10);
    chk_reg("R5", A_CTRL, 32'h3);
    wait_clk(1);
    chk_reg("R5", A_CNT, 32'd0);
    chk_reg("R5", A_CTRL, 32'h7);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_decode();
    t_periodic();
    t_stop();
    t_collide();
    t_shrink();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule